// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Sequence

This peripheral supervises software through a countdown that must be refreshed periodically. Software programs an expiry time in half-second steps through a 16-bit register port and then arms the counter. Once armed, the counter can never be stopped. It is restarted only when two fixed key words reach the service register in the correct order. If software stops refreshing it, the counter expires. Expiry then either drives a fixed-length reset request pulse or, when external-reset mode and the interrupt enable are both set, sets a sticky interrupt status bit.

A prescaler divides the clock into half-second ticks, and the tick length is a parameter so that a short simulation can use a small value. An independent power-down counter runs from reset and requests a reset after a fixed number of ticks unless software clears its enable first. The bus fabric, clock generation and reset distribution are outside the block. The reset request is an output only and does not reset the block itself.

Top module: `wdog_top`

## Requirements
- R1: After reset, reads return 0x0000 at CTRL (address 0), 0x0000 at ICTRL (address 2) and 0x0001 at MISC (address 3), and SVC (address 1) always reads 0x0000. After reset, rst_req_o and irq_o are low.
- R2: CTRL bits 15:8 hold the timeout field F. With counting enabled, expiry occurs F+1 ticks after the last reload, and a tick is TICK_CYCLES clock cycles.
- R3: The counter reloads only when an SVC write of 0x5555 is followed by an SVC write of 0xAAAA. Any other SVC value in between, or the opposite order, reloads nothing.
- R4: CTRL bit 0 is the enable and is set-only: a write of 0 to it is ignored. While the enable is clear, the watchdog never expires.
- R5: MISC bit 0 is the power-down enable. It resets to 1 and can only be cleared. While it is set, a reset request is raised PD_TICKS ticks after reset, once. Clearing it before then prevents the request.
- R6: A reset request is a pulse on rst_req_o that is high for exactly RST_PULSE_CYCLES cycles.
- R7: With CTRL bit 1 (external-reset mode) and ICTRL bit 0 (interrupt enable) both set, expiry sets ICTRL bit 15 (status) and drives irq_o high instead of raising a reset request.
- R8: Writing ICTRL with bit 15 set clears the status and irq_o. Bit 0 of the same write updates the interrupt enable.
- R9: With external-reset mode set but the interrupt enable clear, expiry raises the reset request and leaves the status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt: status AND interrupt enable |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The checker watches four properties on every cycle: the enable and the power-down enable never return once gone, every reset pulse lasts the full length and follows an expiry, the status bit is only set when both interrupt conditions hold, and a clear request takes effect. Timing belongs to the bench scenarios. These cover the expiry window for a given field, a reload that is postponed by a valid key pair, aborted and reversed key pairs, the power-down expiry and its suppression, and the split between interrupt and reset when the interrupt enable is toggled.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_SVC   = 2'd1,
    ADDR_ICTRL = 2'd2,
    ADDR_MISC  = 2'd3
  } wdog_addr_e;

  localparam logic [15:0] KEY_FIRST  = 16'h5555;
  localparam logic [15:0] KEY_SECOND = 16'hAAAA;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_EXT_BIT = 1;
  localparam int CTRL_TMO_LSB = 8;
  localparam int TMO_W        = 8;
  localparam int ICTRL_IE_BIT = 0;
  localparam int ICTRL_ST_BIT = 15;
  localparam int MISC_PD_BIT  = 0;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_CYCLES = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_CYCLES - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq #(
  parameter int          DW   = 16,
  parameter logic [DW-1:0] KEY_A = 16'h5555,
  parameter logic [DW-1:0] KEY_B = 16'hAAAA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          reload_o
);
  logic armed_q;

  assign reload_o = wr_i && armed_q && (data_i == KEY_B);

  // any service write other than the first key drops the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_A);
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && tick_i && !reload_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || reload_i) cnt_q <= load_i;
    else if (tick_i) begin
      if (cnt_q == '0) cnt_q <= load_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] cnt_q;

  assign pulse_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (trig_i)  cnt_q <= PW'(PULSE_CYCLES);
    else if (pulse_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TICK_CYCLES      = 16384,
  parameter int RST_PULSE_CYCLES = 16,
  parameter int PD_TICKS         = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int PD_W = (PD_TICKS > 1) ? $clog2(PD_TICKS) : 1;
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(PD_TICKS - 1);

  logic             tick;
  logic             en_q, ext_q, ie_q, irq_stat_q, pd_en_q, pd_done_q;
  logic [TMO_W-1:0] tmo_q;
  logic [PD_W-1:0]  pd_cnt_q;
  logic             ctrl_wr, svc_wr, ictrl_wr, misc_wr, stat_clr;
  logic             svc_reload, wd_expire, pd_expire, irq_path, irq_set, rst_trig;

  assign ctrl_wr  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign svc_wr   = reg_we_i && (reg_addr_i == ADDR_SVC);
  assign ictrl_wr = reg_we_i && (reg_addr_i == ADDR_ICTRL);
  assign misc_wr  = reg_we_i && (reg_addr_i == ADDR_MISC);
  assign stat_clr = ictrl_wr && reg_wdata_i[ICTRL_ST_BIT];

  wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  wdog_svc_seq #(.DW(16), .KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) u_seq (
    .clk_i, .rst_ni, .wr_i(svc_wr), .data_i(reg_wdata_i), .reload_o(svc_reload)
  );

  wdog_countdown #(.CNT_W(TMO_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(en_q), .tick_i(tick), .reload_i(svc_reload),
    .load_i(tmo_q), .expire_o(wd_expire)
  );

  assign irq_path  = ext_q && ie_q;
  assign irq_set   = wd_expire && irq_path;
  assign pd_expire = pd_en_q && !pd_done_q && tick && (pd_cnt_q == PD_LAST);
  assign rst_trig  = (wd_expire && !irq_path) || pd_expire;

  wdog_pulse #(.PULSE_CYCLES(RST_PULSE_CYCLES)) u_pulse (
    .clk_i, .rst_ni, .trig_i(rst_trig), .pulse_o(rst_req_o)
  );

  // control: enable is set-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ext_q <= 1'b0;
      tmo_q <= '0;
    end else if (ctrl_wr) begin
      en_q  <= en_q | reg_wdata_i[CTRL_EN_BIT];
      ext_q <= reg_wdata_i[CTRL_EXT_BIT];
      tmo_q <= reg_wdata_i[CTRL_TMO_LSB +: TMO_W];
    end
  end

  // interrupt control; a new expiry wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q       <= 1'b0;
      irq_stat_q <= 1'b0;
    end else begin
      if (ictrl_wr) ie_q <= reg_wdata_i[ICTRL_IE_BIT];
      if (irq_set)       irq_stat_q <= 1'b1;
      else if (stat_clr) irq_stat_q <= 1'b0;
    end
  end

  // power-down counter: enable clear-only, fires once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_en_q   <= 1'b1;
      pd_cnt_q  <= '0;
      pd_done_q <= 1'b0;
    end else begin
      if (misc_wr) pd_en_q <= pd_en_q & reg_wdata_i[MISC_PD_BIT];
      if (pd_expire) pd_done_q <= 1'b1;
      if (pd_en_q && !pd_done_q && tick) pd_cnt_q <= pd_cnt_q + 1'b1;
    end
  end

  assign irq_o = irq_stat_q && ie_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT]                = en_q;
        reg_rdata_o[CTRL_EXT_BIT]               = ext_q;
        reg_rdata_o[CTRL_TMO_LSB +: TMO_W]      = tmo_q;
      end
      ADDR_ICTRL: begin
        reg_rdata_o[ICTRL_IE_BIT] = ie_q;
        reg_rdata_o[ICTRL_ST_BIT] = irq_stat_q;
      end
      ADDR_MISC: reg_rdata_o[MISC_PD_BIT] = pd_en_q;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int RST_PULSE_CYCLES = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_req_o,
  input logic irq_stat_q,
  input logic ext_q,
  input logic ie_q,
  input logic en_q,
  input logic pd_en_q,
  input logic wd_expire,
  input logic pd_expire,
  input logic stat_clr
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= 0;
    else if (rst_req_o) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  p_en_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);

  p_pd_clear_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_en_q |=> !pd_en_q);

  p_pulse_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (hi_cnt >= RST_PULSE_CYCLES));

  p_pulse_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(wd_expire || pd_expire));

  p_stat_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_stat_q) |-> $past(ext_q && ie_q && wd_expire));

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !wd_expire) |=> !irq_stat_q);
endmodule

bind wdog_top wdog_checker #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_o  (rst_req_o),
  .irq_stat_q (irq_stat_q),
  .ext_q      (ext_q),
  .ie_q       (ie_q),
  .en_q       (en_q),
  .pd_en_q    (pd_en_q),
  .wd_expire  (wd_expire),
  .pd_expire  (pd_expire),
  .stat_clr   (stat_clr)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int TICK  = 4;
  localparam int PULSE = 6;
  localparam int PDT   = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq, rst_req;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.TICK_CYCLES(TICK), .RST_PULSE_CYCLES(PULSE), .PD_TICKS(PDT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  // {addr, write data, expected readback}
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 16'h0302, 16'h0302},   // R2 field, ext mode, enable clear
    {2'd2, 16'h0001, 16'h0001},   // R8 ie
    {2'd2, 16'h0000, 16'h0000},
    {2'd3, 16'h0001, 16'h0000},   // R5 cannot set again
    {2'd1, 16'h1234, 16'h0000},   // R1 svc reads zero
    {2'd0, 16'h0500, 16'h0500},
    {2'd0, 16'h0501, 16'h0501},   // R4 enable
    {2'd0, 16'h0700, 16'h0701}    // R4 clear ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
    addr = a;
    #1;
    check(rdata == exp, req, int'(rdata), int'(exp));
  endtask

  task automatic service();
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'hAAAA);
  endtask

  // waits for signal (0=rst_req, 1=irq) and returns cycles since c0
  task automatic wait_hi(input int sel, input int c0, input int maxc, output int k);
    int lim;
    lim = cyc + maxc;
    while (!((sel == 0) ? rst_req : irq) && cyc < lim) @(negedge clk);
    k = cyc - c0;
  endtask

  task automatic wait_rst_low();
    while (rst_req) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    int k, c0, w;
    bit seen;

    // R1: reset values, read during reset
    do_reset();
    rd_chk(2'd0, 16'h0000, "R1 ctrl");
    rd_chk(2'd1, 16'h0000, "R1 svc");
    rd_chk(2'd2, 16'h0000, "R1 ictrl");
    rd_chk(2'd3, 16'h0001, "R1 misc");
    check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R5: power-down expiry after PDT ticks; R6 pulse width
    rst_ni = 1'b1;
    c0 = cyc;
    wait_hi(0, c0, PDT * TICK + 10, k);
    check(k >= PDT * TICK - 1 && k <= PDT * TICK + 1, "R5 pd expiry", k, PDT * TICK);
    w = 0;
    while (rst_req && w < 100) begin w++; @(negedge clk); end
    check(w == PULSE, "R6 pulse width", w, PULSE);
    // fires once only
    seen = 1'b0;
    repeat (PDT * TICK + 8) begin @(negedge clk); if (rst_req) seen = 1'b1; end
    check(!seen, "R5 pd single shot", seen, 0);

    // R5 clear prevents, R4 disabled never expires
    do_reset();
    rst_ni = 1'b1;
    wr(2'd3, 16'h0000);
    seen = 1'b0;
    repeat (20 * TICK) begin @(negedge clk); if (rst_req) seen = 1'b1; end
    check(!seen, "R5 R4 no request", seen, 0);

    // table walk
    foreach (VEC[i]) begin
      wr(VEC[i][33:32], VEC[i][31:16]);
      rd_chk(VEC[i][33:32], VEC[i][15:0], "R1 R4 R5 table");
    end

    // R2: expiry window for field 7
    service();
    c0 = cyc;
    wait_hi(0, c0, 12 * TICK, k);
    check(k >= 7 * TICK + 1 && k <= 8 * TICK, "R2 expiry window", k, 8 * TICK);
    wait_rst_low();

    // R3: valid pair postpones expiry
    service();
    seen = 1'b0;
    repeat (5 * TICK) begin @(negedge clk); if (rst_req) seen = 1'b1; end
    check(!seen, "R3 no early expiry", seen, 0);
    service();
    c0 = cyc;
    wait_hi(0, c0, 12 * TICK, k);
    check(k >= 7 * TICK + 1 && k <= 8 * TICK, "R3 reload postponed", k, 8 * TICK);
    wait_rst_low();

    // R3: aborted and reversed pairs do not reload
    service();
    c0 = cyc;
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'h1234);
    wr(2'd1, 16'hAAAA);
    wr(2'd1, 16'hAAAA);
    wr(2'd1, 16'h5555);
    wait_hi(0, c0, 12 * TICK, k);
    check(k >= 7 * TICK + 1 && k <= 8 * TICK, "R3 bad pairs ignored", k, 8 * TICK);
    wait_rst_low();

    // R7: ext mode with ie -> interrupt, no reset
    wr(2'd0, 16'h0702);
    wr(2'd2, 16'h0001);
    service();
    c0 = cyc;
    seen = 1'b0;
    while (!irq && cyc < c0 + 12 * TICK) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    k = cyc - c0;
    check(k >= 7 * TICK + 1 && k <= 8 * TICK, "R7 irq window", k, 8 * TICK);
    check(!seen, "R7 no reset", seen, 0);
    rd_chk(2'd2, 16'h8001, "R7 status");
    rd_chk(2'd0, 16'h0703, "R4 enable kept");

    // R8: write-one-to-clear
    wr(2'd2, 16'h8001);
    rd_chk(2'd2, 16'h0001, "R8 cleared");
    check(irq == 1'b0, "R8 irq low", irq, 0);

    // R9: ext mode without ie -> reset
    wr(2'd2, 16'h0000);
    service();
    c0 = cyc;
    wait_hi(0, c0, 12 * TICK, k);
    check(k >= 7 * TICK + 1 && k <= 8 * TICK, "R9 reset window", k, 8 * TICK);
    rd_chk(2'd2, 16'h0000, "R9 status clear");
    check(irq == 1'b0, "R9 irq low", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule